// File: doc/BRIEF.md
# Hysteresis Threshold Sample Discriminator

This block watches several parallel sample streams and passes on only the parts of each stream that are of interest. Each channel has its own pair of unsigned thresholds, an upper one and a lower one. A channel becomes active when a sample rises above its upper threshold. It stays active until a sample drops below its lower threshold. While a channel is active, its samples are forwarded one cycle after they arrive. Everything else is dropped. Setting the lower threshold well below the upper one gives strong hysteresis. Setting the two equal makes the gate act as a plain comparator.

Each time a channel goes from inactive to active, the block emits a timestamp record for that channel. The record has two parts. The low part is the index at which the region's first sample will sit in that channel's sample store. This index is a per-channel count of forwarded samples. Above it sits a free-running clock count. The record is zero-padded up to a whole number of samples. A rising edge on the capture-start input clears every channel's index, so each capture numbers its samples from zero. All thresholds are loaded together from one packed configuration word.

Top module: `hyst_discriminator`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, every valid output is low. Reset leaves every channel inactive and every index at zero. It also sets each upper threshold to all ones and each lower threshold to zero, so no sample is forwarded until thresholds are loaded.
- R2: Channel c's thresholds are taken from bits [2·SAMP_W·c +: 2·SAMP_W] of `cfg_word_i`. The upper threshold is the top SAMP_W bits of that slice and the lower threshold is the bottom SAMP_W bits. A word presented with `cfg_vld_i` high applies to samples from the next cycle onward. A sample in the same cycle is still judged against the old thresholds.
- R3: On a valid sample, an inactive channel becomes active if the sample is strictly greater than its upper threshold. An active channel becomes inactive if the sample is strictly less than its lower threshold. Any other valid sample leaves the state unchanged, and cycles without a valid sample never change it.
- R4: A valid sample appears on `fwd_smp_o` with `fwd_vld_o` high one cycle later if, and only if, the channel is active after that sample. A sample that is below the lower threshold and not above the upper one is never forwarded.
- R5: The sample that activates a channel raises that channel's `tstamp_vld_o` one cycle later, in the same cycle as that sample is forwarded. No other sample raises `tstamp_vld_o`.
- R6: A timestamp is TS_W = SAMP_W·ceil((IDX_W+CLK_W)/SAMP_W) bits wide, where IDX_W = clog2(BUF_DEPTH·NUM_CH). Bits [IDX_W-1:0] hold the sample index, bits [IDX_W +: CLK_W] hold the clock count, and every higher bit is zero.
- R7: Each channel's index counts that channel's forwarded samples modulo 2^IDX_W. A timestamp carries the index assigned to the activating sample.
- R8: A rising edge of `capture_start_i` clears all indexes. A sample arriving in that same cycle receives index 0. Holding the input high does not clear the indexes again.
- R9: The clock count in a timestamp is the number of clock edges between reset release and the activating sample's edge, modulo 2^CLK_W.
- R10: With equal thresholds T, a channel goes active on a sample above T and inactive on a sample below T. A sample equal to T keeps the channel's current state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word_i | input | NUM_CH*2*SAMP_W | Packed per-channel {upper, lower} thresholds |
| cfg_vld_i | input | 1 | Load `cfg_word_i` |
| capture_start_i | input | 1 | Capture start level; its rising edge clears the indexes |
| smp_i | input | NUM_CH*SAMP_W | Incoming samples, channel c at [SAMP_W*c +: SAMP_W] |
| smp_vld_i | input | NUM_CH | Per-channel sample valid |
| fwd_smp_o | output | NUM_CH*SAMP_W | Forwarded samples |
| fwd_vld_o | output | NUM_CH | Per-channel forwarded-sample valid |
| tstamp_o | output | NUM_CH*TS_W | Per-channel timestamp records |
| tstamp_vld_o | output | NUM_CH | Per-channel timestamp valid |

## Verification
The assertions assume the following about the inputs. Samples and thresholds are unsigned. `capture_start_i` is a level that may stay high for many cycles, and only its edge matters. The below-threshold property assumes the lower threshold does not exceed the upper one, so it only constrains samples that are below the lower threshold and not above the upper one. The stimulus meets all of these assumptions. It loads only threshold pairs with lower ≤ upper, holds the capture-start level high for long stretches, and drives ramps and their mirror images through strong-hysteresis, weak-hysteresis, equal-threshold and all-below settings. It uses both a continuous valid pattern and a gapped one, and runs long enough for the clock count and the indexes to wrap.

// File: rtl/hdisc_pkg.sv
package hdisc_pkg;
  // Timestamp width: index plus clock count, rounded up to whole samples
  function automatic int ts_width(int samp_w, int idx_w, int clk_w);
    return samp_w * ((idx_w + clk_w + samp_w - 1) / samp_w);
  endfunction
endpackage

// File: rtl/hdisc_cfg_reg.sv
module hdisc_cfg_reg #(
  parameter int NUM_CH = 2,
  parameter int SAMP_W = 16,
  localparam int SLICE_W = 2 * SAMP_W,
  localparam int WORD_W  = NUM_CH * SLICE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] cfg_word_i,
  input  logic              cfg_vld_i,
  output logic [NUM_CH-1:0][SAMP_W-1:0] thr_hi_o,
  output logic [NUM_CH-1:0][SAMP_W-1:0] thr_lo_o
);
  logic [WORD_W-1:0] thr_q, thr_d;

  always_comb begin
    thr_d = thr_q;
    if (cfg_vld_i) thr_d = cfg_word_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_CH; c++) begin
        thr_q[c*SLICE_W +: SLICE_W] <= {{SAMP_W{1'b1}}, {SAMP_W{1'b0}}};
      end
    end else begin
      thr_q <= thr_d;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_split
    assign thr_hi_o[c] = thr_q[c*SLICE_W + SAMP_W +: SAMP_W];
    assign thr_lo_o[c] = thr_q[c*SLICE_W +: SAMP_W];
  end

  // R2: a loaded word is what the channels see on the next cycle
  assert_cfg_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_vld_i |=> thr_q == $past(cfg_word_i));
endmodule

// File: rtl/hdisc_clock_ctr.sv
module hdisc_clock_ctr #(
  parameter int CLK_W = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CLK_W-1:0] cnt_o
);
  logic [CLK_W-1:0] cnt_q, cnt_d;

  always_comb cnt_d = cnt_q + CLK_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R9: the count advances by exactly one per edge, wrapping naturally
  assert_clk_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> cnt_q == $past(cnt_q) + CLK_W'(1));
endmodule

// File: rtl/hdisc_index_ctr.sv
module hdisc_index_ctr #(
  parameter int IDX_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W-1:0] idx_q, idx_d, idx_base;

  always_comb begin
    idx_base = clr_i ? '0 : idx_q;
    idx_d    = idx_base + IDX_W'(inc_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  assign idx_o = idx_base;

  // R8: after a clear at most the sample of that same cycle has been counted
  assert_start_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> idx_q <= IDX_W'(1));
endmodule

// File: rtl/hdisc_channel.sv
module hdisc_channel #(
  parameter int SAMP_W = 16,
  parameter int IDX_W  = 16,
  parameter int CLK_W  = 48,
  parameter int TS_W   = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SAMP_W-1:0] thr_hi_i,
  input  logic [SAMP_W-1:0] thr_lo_i,
  input  logic [SAMP_W-1:0] smp_i,
  input  logic              smp_vld_i,
  input  logic              idx_clr_i,
  input  logic [CLK_W-1:0]  clk_cnt_i,
  output logic [SAMP_W-1:0] fwd_smp_o,
  output logic              fwd_vld_o,
  output logic [TS_W-1:0]   ts_o,
  output logic              ts_vld_o
);
  logic              act_q, act_d, act_cand;
  logic              above, below, take, open;
  logic [IDX_W-1:0]  idx_now;
  logic [TS_W-1:0]   ts_d;
  logic [SAMP_W-1:0] smp_q;
  logic [TS_W-1:0]   ts_q;
  logic              fwd_vld_q, ts_vld_q;

  // Hysteresis gate
  always_comb begin
    above    = smp_i > thr_hi_i;
    below    = smp_i < thr_lo_i;
    act_cand = act_q ? ~below : above;
    take     = smp_vld_i & act_cand;
    open     = smp_vld_i & ~act_q & act_cand;
    act_d    = smp_vld_i ? act_cand : act_q;
  end

  hdisc_index_ctr #(.IDX_W(IDX_W)) u_idx (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (idx_clr_i),
    .inc_i (take),
    .idx_o (idx_now)
  );

  // Timestamp record: index low, clock count above, zero padding on top
  always_comb begin
    ts_d = '0;
    ts_d[IDX_W-1:0]     = idx_now;
    ts_d[IDX_W +: CLK_W] = clk_cnt_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q     <= 1'b0;
      fwd_vld_q <= 1'b0;
      ts_vld_q  <= 1'b0;
      smp_q     <= '0;
      ts_q      <= '0;
    end else begin
      act_q     <= act_d;
      fwd_vld_q <= take;
      ts_vld_q  <= open;
      if (smp_vld_i) smp_q <= smp_i;
      if (open)      ts_q  <= ts_d;
    end
  end

  assign fwd_smp_o = smp_q;
  assign fwd_vld_o = fwd_vld_q;
  assign ts_o      = ts_q;
  assign ts_vld_o  = ts_vld_q;

  // R5: a timestamp always travels with the region's first forwarded sample
  assert_ts_with_fwd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ts_vld_o |-> fwd_vld_o);

  // R4: a sample below the lower threshold and not above the upper is dropped
  assert_below_dropped_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld_i && (smp_i < thr_lo_i) && (smp_i <= thr_hi_i)) |=> !fwd_vld_o);

  // R3: cycles without a valid sample hold the state and emit nothing
  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld_i |=> (act_q == $past(act_q)) && !fwd_vld_o && !ts_vld_o);
endmodule

// File: rtl/hyst_discriminator.sv
module hyst_discriminator #(
  parameter int NUM_CH    = 2,
  parameter int SAMP_W    = 16,
  parameter int BUF_DEPTH = 32768,
  parameter int CLK_W     = 48,
  localparam int IDX_W    = $clog2(BUF_DEPTH * NUM_CH),
  localparam int TS_W     = hdisc_pkg::ts_width(SAMP_W, IDX_W, CLK_W)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_CH*2*SAMP_W-1:0] cfg_word_i,
  input  logic                       cfg_vld_i,
  input  logic                       capture_start_i,
  input  logic [NUM_CH*SAMP_W-1:0]   smp_i,
  input  logic [NUM_CH-1:0]          smp_vld_i,
  output logic [NUM_CH*SAMP_W-1:0]   fwd_smp_o,
  output logic [NUM_CH-1:0]          fwd_vld_o,
  output logic [NUM_CH*TS_W-1:0]     tstamp_o,
  output logic [NUM_CH-1:0]          tstamp_vld_o
);
  logic [NUM_CH-1:0][SAMP_W-1:0] thr_hi, thr_lo;
  logic [CLK_W-1:0]              clk_cnt;
  logic                          start_q, start_d, start_pulse;

  // Capture-start edge detect
  always_comb begin
    start_d     = capture_start_i;
    start_pulse = capture_start_i & ~start_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) start_q <= 1'b0;
    else        start_q <= start_d;
  end

  hdisc_cfg_reg #(.NUM_CH(NUM_CH), .SAMP_W(SAMP_W)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_word_i (cfg_word_i),
    .cfg_vld_i  (cfg_vld_i),
    .thr_hi_o   (thr_hi),
    .thr_lo_o   (thr_lo)
  );

  hdisc_clock_ctr #(.CLK_W(CLK_W)) u_clk (
    .clk   (clk),
    .rst_n (rst_n),
    .cnt_o (clk_cnt)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    hdisc_channel #(
      .SAMP_W (SAMP_W),
      .IDX_W  (IDX_W),
      .CLK_W  (CLK_W),
      .TS_W   (TS_W)
    ) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .thr_hi_i  (thr_hi[c]),
      .thr_lo_i  (thr_lo[c]),
      .smp_i     (smp_i[c*SAMP_W +: SAMP_W]),
      .smp_vld_i (smp_vld_i[c]),
      .idx_clr_i (start_pulse),
      .clk_cnt_i (clk_cnt),
      .fwd_smp_o (fwd_smp_o[c*SAMP_W +: SAMP_W]),
      .fwd_vld_o (fwd_vld_o[c]),
      .ts_o      (tstamp_o[c*TS_W +: TS_W]),
      .ts_vld_o  (tstamp_vld_o[c])
    );
  end

  // R1: the first cycle after reset carries no output
  assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (fwd_vld_o == '0) && (tstamp_vld_o == '0));
endmodule

// File: tb/tb_hyst_discriminator.sv
module tb_hyst_discriminator;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 2;
  localparam int SW = 8;
  localparam int BD = 16;
  localparam int CW = 12;
  localparam int IW = 5;   // clog2(16*2)
  localparam int TW = 24;  // 8*ceil(17/8)

  logic              clk;
  logic              rst_n;
  logic [NC*2*SW-1:0] cfg_word_i;
  logic              cfg_vld_i;
  logic              capture_start_i;
  logic [NC*SW-1:0]  smp_i;
  logic [NC-1:0]     smp_vld_i;
  logic [NC*SW-1:0]  fwd_smp_o;
  logic [NC-1:0]     fwd_vld_o;
  logic [NC*TW-1:0]  tstamp_o;
  logic [NC-1:0]     tstamp_vld_o;

  hyst_discriminator #(.NUM_CH(NC), .SAMP_W(SW), .BUF_DEPTH(BD), .CLK_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_word_i(cfg_word_i), .cfg_vld_i(cfg_vld_i),
    .capture_start_i(capture_start_i), .smp_i(smp_i), .smp_vld_i(smp_vld_i),
    .fwd_smp_o(fwd_smp_o), .fwd_vld_o(fwd_vld_o), .tstamp_o(tstamp_o),
    .tstamp_vld_o(tstamp_vld_o)
  );

  int n_chk = 0;
  int n_err = 0;
  int edges = 0;
  bit finished = 0;

  // reference model state
  bit          m_act [NC];
  int          m_idx [NC];
  int          m_hi  [NC];
  int          m_lo  [NC];
  bit          m_sp;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) if (rst_n) edges <= edges + 1;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [2*SW-1:0] pair(input int hi, input int lo);
    return {SW'(hi), SW'(lo)};
  endfunction

  // one cycle: drive at negedge, predict, check at the next negedge
  task automatic step(input int s0, input int s1, input logic [NC-1:0] v,
                      input bit st, input bit cv, input logic [NC*2*SW-1:0] cw,
                      input string phase);
    bit pulse;
    int clkv;
    bit e_fv [NC];
    bit e_tv [NC];
    int e_s  [NC];
    logic [TW-1:0] e_ts [NC];
    smp_i           = {SW'(s1), SW'(s0)};
    smp_vld_i       = v;
    capture_start_i = st;
    cfg_vld_i       = cv;
    cfg_word_i      = cw;
    clkv  = edges % (1 << CW);
    pulse = st && !m_sp;
    m_sp  = st;
    for (int c = 0; c < NC; c++) begin
      int s, base;
      bit nxt;
      s    = (c == 0) ? s0 : s1;
      e_s[c] = s;
      base = pulse ? 0 : m_idx[c];
      nxt  = m_act[c] ? !(s < m_lo[c]) : (s > m_hi[c]);
      e_fv[c] = v[c] && nxt;
      e_tv[c] = v[c] && !m_act[c] && nxt;
      e_ts[c] = '0;
      e_ts[c][IW-1:0] = IW'(base);
      e_ts[c][IW +: CW] = CW'(clkv);
      if (v[c]) m_act[c] = nxt;
      m_idx[c] = (base + (e_fv[c] ? 1 : 0)) % (1 << IW);
    end
    if (cv) begin
      for (int c = 0; c < NC; c++) begin
        m_hi[c] = int'(cw[c*2*SW + SW +: SW]);
        m_lo[c] = int'(cw[c*2*SW +: SW]);
      end
    end
    @(negedge clk);
    for (int c = 0; c < NC; c++) begin
      check({phase, " R4 fwd_vld"}, 64'(fwd_vld_o[c]), 64'(e_fv[c]));
      if (e_fv[c]) check({phase, " R4 fwd_smp"}, 64'(fwd_smp_o[c*SW +: SW]), 64'(e_s[c]));
      check({phase, " R5 ts_vld"}, 64'(tstamp_vld_o[c]), 64'(e_tv[c]));
      if (e_tv[c]) begin
        check({phase, " R7 ts index"}, 64'(tstamp_o[c*TW +: IW]), 64'(e_ts[c][IW-1:0]));
        check({phase, " R9 ts clock"}, 64'(tstamp_o[c*TW + IW +: CW]), 64'(e_ts[c][IW +: CW]));
        check({phase, " R6 ts record"}, 64'(tstamp_o[c*TW +: TW]), 64'(e_ts[c]));
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [NC*2*SW-1:0] cfgs [4];
    rst_n = 1'b0;
    cfg_word_i = '0;
    cfg_vld_i = 1'b0;
    capture_start_i = 1'b0;
    smp_i = '0;
    smp_vld_i = '0;
    m_sp = 0;
    for (int c = 0; c < NC; c++) begin
      m_act[c] = 0; m_idx[c] = 0; m_hi[c] = (1 << SW) - 1; m_lo[c] = 0;
    end
    repeat (3) @(negedge clk);
    check("R1 reset fwd_vld", 64'(fwd_vld_o), 64'd0);
    check("R1 reset ts_vld", 64'(tstamp_vld_o), 64'd0);
    rst_n = 1'b1;

    // R1: default thresholds let nothing through, even full scale
    step(255, 255, 2'b11, 0, 0, '0, "R1 default");
    step(200, 128, 2'b11, 0, 0, '0, "R1 default");

    // R2: new word judged only from the next cycle; distinct per-channel slices
    step(255, 255, 2'b11, 0, 1, {pair(8'h30, 8'h20), pair(8'h80, 8'h40)}, "R2 same cycle");
    step(8'h50, 8'h50, 2'b11, 0, 0, '0, "R2 slice");
    step(8'h90, 8'h35, 2'b11, 0, 0, '0, "R2 slice");
    step(8'h41, 8'h1f, 2'b11, 0, 0, '0, "R3 hold/drop");
    step(8'h3f, 8'h25, 2'b11, 0, 0, '0, "R3 drop/hold");

    cfgs[0] = {pair(8'hc0, 8'h40), pair(8'hc0, 8'h40)}; // strong hysteresis
    cfgs[1] = {pair(8'h90, 8'h80), pair(8'ha0, 8'h70)}; // weak hysteresis
    cfgs[2] = {pair(8'h80, 8'h80), pair(8'h80, 8'h80)}; // all samples below
    cfgs[3] = {pair(8'h60, 8'h60), pair(8'h33, 8'h33)}; // R10 plain comparator

    for (int set = 0; set < 4; set++) begin
      for (int mode = 0; mode < 2; mode++) begin
        step(0, 0, 2'b00, 0, 1, cfgs[set], "R2 load");
        for (int k = 0; k < 512; k++) begin
          int s, s0, s1;
          logic [NC-1:0] v;
          bit st;
          s  = (k < 256) ? k : 511 - k;
          s0 = s;
          s1 = 255 - s;
          if (set == 2) begin s0 = s0 & 8'h7f; s1 = s1 & 8'h7f; end
          if (set == 3 && (k % 7) == 0) begin s0 = 8'h60; s1 = 8'h33; end
          v  = (mode == 0) ? 2'b11 : {1'(k[1] ^ k[2]), 1'(k[0] | k[3])};
          st = ((k % 128) >= 10) && ((k % 128) < 60);  // R8 edge then held
          step(s0, s1, v, st, 0, '0,
               (set == 3) ? "R10 sweep" : (set == 2) ? "R4 below" : "R3 sweep");
        end
      end
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule